// File: doc/BRIEF.md
# Arbitrated Dual-Port Mailbox RAM

This block is a 512-word by 16-bit shared memory that sits between an on-chip processor and an off-chip coprocessor. The on-chip side sees a simple synchronous port: one request per cycle, with the read word returned on the next cycle and per-byte write enables. The off-chip side sees what looks like an asynchronous static RAM. It has a word address, an active-low select, an active-low output enable, a read/not-write line and two active-low byte-lane selects. Its external strobes are assumed to be already synchronous to `clk`.

Only one side owns the memory at a time. The coprocessor raises a bus request. An arbitration state machine hands ownership over and answers with a bus grant. While the grant is out, the on-chip port is stalled and its requests are dropped. The machine has three states: `ST_INT` (on-chip owns), `ST_WAIT` (request seen, handover pending) and `ST_EXT` (coprocessor owns, grant high). Its transitions are:
- `ST_INT` to `ST_WAIT` on request.
- `ST_WAIT` to `ST_EXT` while the request stays high.
- `ST_WAIT` to `ST_INT` if the request is withdrawn early.
- `ST_EXT` to `ST_INT` when the request falls.
- Every other case holds the current state.

An off-chip write is captured on every cycle it is active. It is committed to the array on the first cycle after it ends. The write ends when any one of three things happens: read/not-write returns high, the select is released, or both byte selects are released. Read data is driven combinationally, lane by lane, through per-lane output enables.

Top module: `mbox_ram`

## Requirements
- R1: After reset, `ext_bgnt`, `int_stall` and both bits of `ext_dout_oe` are 0, and `int_rdata` is 0.
- R2: When `ext_breq` is high at two consecutive rising edges starting from `ST_INT`, `ext_bgnt` is still 0 after the first edge and is 1 after the second, which is one to two clock periods after the request.
- R3: When `ext_breq` is low at a rising edge while `ext_bgnt` is 1, `ext_bgnt` is 0 after that edge.
- R4: `int_stall` is 1 in `ST_WAIT` and `ST_EXT`. An on-chip write issued while stalled leaves the array unchanged, and an on-chip read issued while stalled leaves `int_rdata` unchanged.
- R5: While `ext_bgnt` is 0, off-chip writes do not change the array and `ext_dout_oe` stays 0.
- R6: An off-chip write is committed at the edge after whichever ends it first: `ext_rnw` high, `ext_cs_n` high, or both byte selects high. The address, data and lanes used are those of the last active cycle.
- R7: Bit 0 of the lane set is the lower byte (data bits 7:0, `ext_lb_n`, `int_be[0]`) and bit 1 is the upper byte (bits 15:8, `ext_ub_n`, `int_be[1]`). A write changes only the enabled bytes.
- R8: `ext_dout_oe[0]` is 1 exactly when grant is held, `ext_cs_n`=0, `ext_oe_n`=0, `ext_rnw`=1 and `ext_lb_n`=0. Bit 1 follows the same rule with `ext_ub_n`. `ext_dout` shows the word at `ext_addr` in the same cycle.
- R9: An on-chip read issued at an edge while unstalled returns the word at that address on `int_rdata` after that edge. An on-chip write takes effect at its edge.
- R10: An off-chip write that is still active when ownership returns to the on-chip side is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_en | input | 1 | On-chip access request |
| int_we | input | 1 | On-chip write (1) or read (0) |
| int_be | input | 2 | On-chip byte write enables |
| int_addr | input | ADDR_W | On-chip word address |
| int_wdata | input | 16 | On-chip write data |
| int_rdata | output | 16 | On-chip read data, registered |
| int_stall | output | 1 | On-chip port blocked |
| ext_breq | input | 1 | Off-chip bus request |
| ext_bgnt | output | 1 | Off-chip bus grant |
| ext_addr | input | ADDR_W | Off-chip word address |
| ext_cs_n | input | 1 | Off-chip select, active low |
| ext_oe_n | input | 1 | Off-chip output enable, active low |
| ext_rnw | input | 1 | Off-chip read (1) / write (0) |
| ext_lb_n | input | 1 | Lower byte select, active low |
| ext_ub_n | input | 1 | Upper byte select, active low |
| ext_din | input | 16 | Off-chip write data |
| ext_dout | output | 16 | Off-chip read data |
| ext_dout_oe | output | 2 | Per-lane data bus drive enables |

## Verification
Grant appears after the second edge that sees the request and falls after the first edge that sees it withdrawn. On-chip read data is due one edge after the request, and an off-chip write lands one edge after its ending strobe. Off-chip read data and its lane enables are combinational, so they are checked in the same half-cycle that the strobes change. The bench drives every input just after a falling edge and checks just after the next falling edge, or a few nanoseconds after a change for combinational results. Each registered result is therefore sampled exactly one edge after its cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        ST_INT  = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXT  = 2'd2
    } own_state_e;
endpackage

// File: rtl/mbox_arb.sv
module mbox_arb
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic breq,
    output logic bgnt,
    output logic stall
);
    own_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INT:  if (breq)  state_d = ST_WAIT;
            ST_WAIT: state_d = breq ? ST_EXT : ST_INT;
            ST_EXT:  if (!breq) state_d = ST_INT;
            default: state_d = ST_INT;
        endcase
    end

    always_comb begin
        bgnt  = 1'b0;
        stall = 1'b0;
        unique case (state_q)
            ST_INT:  ;
            ST_WAIT: stall = 1'b1;
            ST_EXT:  begin bgnt = 1'b1; stall = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbox_wrtrack.sv
module mbox_wrtrack
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              granted,
    input  logic              cs_n,
    input  logic              rnw,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [WORD_W-1:0] c_data,
    output logic [LANES-1:0]  c_be
);
    logic active, act_q;

    assign active = granted & ~cs_n & ~rnw & (~lb_n | ~ub_n);
    assign commit = act_q & ~active & granted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            c_addr <= '0;
            c_data <= '0;
            c_be   <= '0;
        end else begin
            act_q <= active;
            if (active) begin
                c_addr <= addr;
                c_data <= din;
                c_be   <= {~ub_n, ~lb_n};
            end
        end
    end
endmodule

// File: rtl/mbox_array.sv
module mbox_array
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [WORD_W-1:0] ra_data,
    input  logic              rb_en,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g])
                mem[wr_addr][g*BYTE_W +: BYTE_W] <= wr_data[g*BYTE_W +: BYTE_W];
        end
    end

    assign ra_data = mem[ra_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rb_data <= '0;
        else if (rb_en) rb_data <= mem[rb_addr];
    end
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_en,
    input  logic              int_we,
    input  logic [1:0]        int_be,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [15:0]       int_wdata,
    output logic [15:0]       int_rdata,
    output logic              int_stall,
    input  logic              ext_breq,
    output logic              ext_bgnt,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ext_cs_n,
    input  logic              ext_oe_n,
    input  logic              ext_rnw,
    input  logic              ext_lb_n,
    input  logic              ext_ub_n,
    input  logic [15:0]       ext_din,
    output logic [15:0]       ext_dout,
    output logic [1:0]        ext_dout_oe
);
    logic              commit;
    logic [ADDR_W-1:0] c_addr;
    logic [WORD_W-1:0] c_data;
    logic [LANES-1:0]  c_be;
    logic              int_go;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic [LANES-1:0]  wr_be;
    logic              rd_drive;

    mbox_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .breq  (ext_breq),
        .bgnt  (ext_bgnt),
        .stall (int_stall)
    );

    mbox_wrtrack #(.ADDR_W(ADDR_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .granted (ext_bgnt),
        .cs_n    (ext_cs_n),
        .rnw     (ext_rnw),
        .lb_n    (ext_lb_n),
        .ub_n    (ext_ub_n),
        .addr    (ext_addr),
        .din     (ext_din),
        .commit  (commit),
        .c_addr  (c_addr),
        .c_data  (c_data),
        .c_be    (c_be)
    );

    assign int_go  = int_en & ~int_stall;
    assign wr_en   = commit | (int_go & int_we);
    assign wr_addr = commit ? c_addr : int_addr;
    assign wr_data = commit ? c_data : int_wdata;
    assign wr_be   = commit ? c_be   : int_be;

    mbox_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .ra_addr (ext_addr),
        .ra_data (ext_dout),
        .rb_en   (int_go & ~int_we),
        .rb_addr (int_addr),
        .rb_data (int_rdata)
    );

    assign rd_drive    = ext_bgnt & ~ext_cs_n & ~ext_oe_n & ext_rnw;
    assign ext_dout_oe = {rd_drive & ~ext_ub_n, rd_drive & ~ext_lb_n};
endmodule

module mbox_ram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_breq,
    input logic       ext_bgnt,
    input logic       int_stall,
    input logic       ext_cs_n,
    input logic       ext_oe_n,
    input logic       ext_rnw,
    input logic [1:0] ext_dout_oe
);
    assert_grant_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_bgnt) |-> ($past(ext_breq, 1) && $past(ext_breq, 2)));

    assert_grant_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bgnt && !ext_breq) |=> !ext_bgnt);

    assert_stall_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bgnt |-> int_stall);

    assert_no_drive_ungranted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_bgnt |-> (ext_dout_oe == 2'b00));

    assert_drive_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_dout_oe != 2'b00) |-> (!ext_cs_n && !ext_oe_n && ext_rnw));
endmodule

bind mbox_ram mbox_ram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_breq    (ext_breq),
    .ext_bgnt    (ext_bgnt),
    .int_stall   (int_stall),
    .ext_cs_n    (ext_cs_n),
    .ext_oe_n    (ext_oe_n),
    .ext_rnw     (ext_rnw),
    .ext_dout_oe (ext_dout_oe)
);

// File: tb/mbox_ram_test.sv
`timescale 1ns/1ps
module mbox_ram_test;
    localparam int AW = 9;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          int_en = 0, int_we = 0;
    logic [1:0]    int_be = 0;
    logic [AW-1:0] int_addr = 0;
    logic [15:0]   int_wdata = 0;
    logic [15:0]   int_rdata;
    logic          int_stall;
    logic          ext_breq = 0;
    logic          ext_bgnt;
    logic [AW-1:0] ext_addr = 0;
    logic          ext_cs_n = 1, ext_oe_n = 1, ext_rnw = 1, ext_lb_n = 1, ext_ub_n = 1;
    logic [15:0]   ext_din = 0;
    logic [15:0]   ext_dout;
    logic [1:0]    ext_dout_oe;

    logic [15:0] model [N];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mbox_ram #(.ADDR_W(AW)) uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int a, input int salt);
        return 16'((a * 40503 + salt * 977) ^ 16'h5A3C);
    endfunction

    task automatic int_write(input int a, input logic [15:0] d, input logic [1:0] be);
        int_en = 1; int_we = 1; int_addr = AW'(a); int_wdata = d; int_be = be;
        tick();
        int_en = 0; int_we = 0;
    endtask

    task automatic int_read(input int a);
        int_en = 1; int_we = 0; int_addr = AW'(a);
        tick();
        int_en = 0;
    endtask

    task automatic ext_idle();
        ext_cs_n = 1; ext_oe_n = 1; ext_rnw = 1; ext_lb_n = 1; ext_ub_n = 1;
    endtask

    // mode 0: ended by rnw, 1: by chip select, 2: by byte selects
    task automatic ext_write(input int a, input logic [15:0] d, input logic [1:0] lanes, input int mode);
        ext_addr = AW'(a); ext_din = d; ext_cs_n = 0; ext_rnw = 0; ext_oe_n = 1;
        ext_lb_n = ~lanes[0]; ext_ub_n = ~lanes[1];
        tick();
        if (mode == 0)      ext_rnw = 1;
        else if (mode == 1) ext_cs_n = 1;
        else begin ext_lb_n = 1; ext_ub_n = 1; end
        tick();
        ext_idle();
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] l);
        return {l[1] ? d[15:8] : old[15:8], l[0] ? d[7:0] : old[7:0]};
    endfunction

    task automatic ext_read_check(input int a, input logic [1:0] lanes, input string req);
        ext_addr = AW'(a); ext_cs_n = 0; ext_oe_n = 0; ext_rnw = 1;
        ext_lb_n = ~lanes[0]; ext_ub_n = ~lanes[1];
        #1;
        check(ext_dout_oe == lanes, req, 32'(ext_dout_oe), 32'(lanes));
        if (lanes != 0) check(ext_dout == model[a], req, 32'(ext_dout), 32'(model[a]));
        ext_idle();
    endtask

    task automatic acquire();
        ext_breq = 1;
        tick();
        check(ext_bgnt == 0, "R2", 32'(ext_bgnt), 0);
        check(int_stall == 1, "R4", 32'(int_stall), 1);
        tick();
        check(ext_bgnt == 1, "R2", 32'(ext_bgnt), 1);
    endtask

    task automatic release_bus();
        ext_breq = 0;
        tick();
        check(ext_bgnt == 0, "R3", 32'(ext_bgnt), 0);
        check(int_stall == 0, "R4", 32'(int_stall), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #3;
        check(ext_bgnt == 0 && int_stall == 0, "R1", {ext_bgnt, int_stall}, 0);
        check(ext_dout_oe == 0, "R1", 32'(ext_dout_oe), 0);
        check(int_rdata == 0, "R1", 32'(int_rdata), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: fill and read back every word through the on-chip port
        for (int a = 0; a < N; a++) begin
            model[a] = pat(a, 1);
            int_write(a, model[a], 2'b11);
        end
        for (int a = 0; a < N; a++) begin
            int_read(a);
            check(int_rdata == model[a], "R9", 32'(int_rdata), 32'(model[a]));
        end
        // R7: on-chip byte lanes
        for (int a = 0; a < 8; a++) begin
            logic [1:0] l = 2'(a % 2 + 1);
            int_write(a, 16'hC3A5 ^ 16'(a), l);
            model[a] = merge(model[a], 16'hC3A5 ^ 16'(a), l);
            int_read(a);
            check(int_rdata == model[a], "R7", 32'(int_rdata), 32'(model[a]));
        end

        // R5: no grant, writes ignored and no drive
        ext_write(20, 16'hDEAD, 2'b11, 0);
        ext_read_check(20, 2'b00, "R5");
        ext_addr = 20; ext_cs_n = 0; ext_oe_n = 0; ext_rnw = 1; ext_lb_n = 0; ext_ub_n = 0;
        #1 check(ext_dout_oe == 0, "R5", 32'(ext_dout_oe), 0);
        ext_idle();
        int_read(20);
        check(int_rdata == model[20], "R5", 32'(int_rdata), 32'(model[20]));

        // R2, R4: handover and stall
        acquire();
        check(int_stall == 1, "R4", 32'(int_stall), 1);
        int_write(30, 16'h1111, 2'b11);
        int_read(30);
        check(int_rdata == model[20], "R4", 32'(int_rdata), 32'(model[20]));

        // R8: read every word with both lanes, plus single-lane patterns
        for (int a = 0; a < N; a++) ext_read_check(a, 2'b11, "R8");
        for (int a = 0; a < 16; a++) ext_read_check(a, 2'(a % 4), "R8");

        // R6, R7: writes ended each way, each lane set
        for (int a = 64; a < 128; a++) begin
            logic [1:0] l = 2'(a % 3 + 1);
            logic [15:0] d = pat(a, 7);
            ext_write(a, d, l, a % 3);
            model[a] = merge(model[a], d, l);
        end
        for (int a = 64; a < 128; a++) ext_read_check(a, 2'b11, "R6");

        // R6: last active cycle wins
        ext_addr = 200; ext_din = 16'hAAAA; ext_cs_n = 0; ext_rnw = 0; ext_lb_n = 0; ext_ub_n = 0;
        tick();
        ext_addr = 201; ext_din = 16'h5555;
        tick();
        ext_rnw = 1;
        #1 check(ext_dout == model[201], "R6", 32'(ext_dout), 32'(model[201]));
        tick();
        ext_idle();
        model[201] = 16'h5555;
        ext_read_check(201, 2'b11, "R6");
        ext_read_check(200, 2'b11, "R6");

        // R10: write still open when grant is withdrawn
        ext_addr = 210; ext_din = 16'hBEEF; ext_cs_n = 0; ext_rnw = 0; ext_lb_n = 0; ext_ub_n = 0;
        tick();
        ext_breq = 0;
        tick();
        check(ext_bgnt == 0, "R3", 32'(ext_bgnt), 0);
        tick();
        ext_idle();
        int_read(210);
        check(int_rdata == model[210], "R10", 32'(int_rdata), 32'(model[210]));

        // R4: stalled write had no effect
        int_read(30);
        check(int_rdata == model[30], "R4", 32'(int_rdata), 32'(model[30]));

        // R2/R3: withdraw during the handover cycle, then full cycle again
        ext_breq = 1;
        tick();
        ext_breq = 0;
        tick();
        check(ext_bgnt == 0 && int_stall == 0, "R3", {ext_bgnt, int_stall}, 0);
        acquire();
        release_bus();
        int_read(70);
        check(int_rdata == model[70], "R9", 32'(int_rdata), 32'(model[70]));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule